// File: doc/BRIEF.md
# Reserving Set-Associative Tag Controller

This block holds the tags and per-line status of a set-associative cache. It answers lookups, accepts line fills and executes a full flush. Data storage lives elsewhere, and so do the memory interface and address packing. Each way keeps a tag, the full address of the line it holds, valid, dirty and reserved flags, and two timestamps: the cycle of the last hit or fill, and the cycle of the last fill. Either a write-back or a write-through policy is selected by a static mode pin. A second static pin selects victim choice by oldest use (LRU) or oldest fill (FIFO).

Under write-back, a read miss claims a way at lookup time by marking it reserved under the new tag. Later accesses to that tag see a hit under a pending miss, and writes to it mark it dirty before the data arrives. When every way of the addressed set is already reserved, the lookup reports a reservation failure and changes nothing. A fill completes the reservation. Under write-through, nothing is reserved: a fill allocates directly and reports any dirty line it pushes out.

At most one request is taken per clock. The response appears on registered outputs one cycle after the request.

Top module: `reserving_tag_ctrl`

## Requirements
- R1: For an address, the set index is the SET_W bits directly above the OFF_W offset bits, and the tag is every bit above the index; only the addressed set is read or changed by a lookup or fill.
- R2: A request sampled at a clock edge produces rspValid=1 after that edge for exactly one cycle; with no request rspValid is 0. When several request strobes are high together, flush beats fill and fill beats lookup; the losers have no effect. Codes: 0 hit, 1 write-through hit, 2 hit under pending miss, 3 miss without writeback, 4 miss with writeback, 5 reservation failure, 6 fill done, 7 flush done.
- R3: A lookup whose tag matches a valid, unreserved way returns code 0 (write-back) or 1 (write-through), stamps that way's last-use time with the current cycle, and on a write sets its dirty flag.
- R4: A lookup whose tag matches a reserved way returns code 2; a write sets that way's dirty flag. Among matching ways, the lowest index that is valid or reserved decides.
- R5: A lookup miss in write-through mode, or a write lookup miss in write-back mode, returns code 3 and allocates nothing.
- R6: A write-back read miss that finds an invalid, unreserved way reserves the lowest such way under the new tag and returns code 3.
- R7: Otherwise the victim is the valid, unreserved way with the smallest last-use time (LRU) or fill time (FIFO), the lowest index on ties. It becomes reserved, invalid and clean under the new tag. If it was dirty, the code is 4 with rspEvict=1 and rspAddr equal to its stored address; if it was clean, the code is 3.
- R8: A write-back read miss in a set whose ways are all reserved returns code 5 and changes no state.
- R9: A write-back fill returns code 6. The lowest way whose tag matches and that is reserved or valid decides. If it is reserved, it becomes valid and unreserved, keeps its dirty flag, stores the address, and has both timestamps set to the current cycle. If it is already valid, or if no way matches, the fill is discarded.
- R10: A write-through fill returns code 6. If a way is invalid before any valid way with the same tag is reached in ascending order, the line is placed there; if a valid way with the tag is reached first, nothing changes. With every way valid, the policy victim is replaced and reported through rspEvict/rspAddr only when it was dirty. The new line is valid and clean, with both timestamps at the current cycle.
- R11: A flush returns code 7 with rspFlushCnt equal to the number of ways, across all sets, that were valid and dirty. It then clears valid and dirty everywhere and leaves reserved flags and tags untouched.
- R12: After reset every way is invalid, clean and unreserved, and rspValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wbMode | input | 1 | Static policy: 1 write-back, 0 write-through |
| fifoMode | input | 1 | Static victim rule: 1 oldest fill, 0 oldest use |
| reqLookup | input | 1 | Lookup strobe |
| reqFill | input | 1 | Fill strobe |
| reqFlush | input | 1 | Flush strobe |
| reqWrite | input | 1 | Lookup is a write |
| reqAddr | input | ADDR_W | Request address |
| rspValid | output | 1 | Response present |
| rspCode | output | 3 | Outcome code (R2) |
| rspEvict | output | 1 | rspAddr carries a line to write back |
| rspAddr | output | ADDR_W | Address of the dirty line displaced |
| rspFlushCnt | output | CNT_W | Dirty lines counted by a flush |

## Verification
A flush can arrive in the same cycle as a lookup or a fill, and a fill can coincide with a lookup. The bench raises these strobes together on purpose, both in directed sequences and in the random traffic. It judges the outcome by the code returned, which must be the winner's. It then checks the loser's lack of effect through the next lookup to the same line: a lookup that lost to a flush must not have reserved anything, and a lookup that lost to a fill must not have set any dirty flag. A behavioural reference model tracks every way and predicts every response cycle by cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  parameter int ADDR_W = 16;
  parameter int OFF_W  = 2;
  parameter int SETS   = 4;
  parameter int WAYS   = 4;
  parameter int TS_W   = 32;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int CNT_W = $clog2(SETS * WAYS + 1);

  typedef enum logic [2:0] {
    RSP_HIT       = 3'd0,
    RSP_HIT_WT    = 3'd1,
    RSP_HIT_PEND  = 3'd2,
    RSP_MISS      = 3'd3,
    RSP_MISS_WB   = 3'd4,
    RSP_RESV_FAIL = 3'd5,
    RSP_FILLED    = 3'd6,
    RSP_FLUSHED   = 3'd7
  } rspCode_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
    logic              valid;
    logic              dirty;
    logic              resv;
    logic [TS_W-1:0]   lastUsed;
    logic [TS_W-1:0]   fetchTime;
  } wayEntry_t;

  // strobes from the control to the tag store
  typedef struct packed {
    logic             lineWr;
    logic [SET_W-1:0] set;
    logic [WAY_W-1:0] way;
    wayEntry_t        entry;
    logic             flushAll;
  } storeCmd_t;

  typedef struct packed {
    logic              valid;
    rspCode_t          code;
    logic              evict;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  flushCnt;
  } rsp_t;
endpackage

// File: rtl/rtc_store.sv
module rtc_store
  import rtc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  storeCmd_t              cmd,
  input  logic [SET_W-1:0]       rdSet,
  output wayEntry_t [WAYS-1:0]   rowOut,
  output logic [CNT_W-1:0]       dirtyCnt
);
  wayEntry_t [WAYS-1:0] mem [SETS];
  logic [CNT_W-1:0] validCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) mem[s] <= '0;
    end else if (cmd.flushAll) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          mem[s][w].valid <= 1'b0;
          mem[s][w].dirty <= 1'b0;
        end
      end
    end else if (cmd.lineWr) begin
      mem[cmd.set][cmd.way] <= cmd.entry;
    end
  end

  assign rowOut = mem[rdSet];

  always_comb begin
    dirtyCnt = '0;
    validCnt = '0;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (mem[s][w].valid && mem[s][w].dirty) dirtyCnt = dirtyCnt + CNT_W'(1);
        if (mem[s][w].valid) validCnt = validCnt + CNT_W'(1);
      end
    end
  end

  // R11: after a flush no line is left valid
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flushAll |=> (validCnt == '0));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wbMode,
  input  logic                 fifoMode,
  input  logic                 reqLookup,
  input  logic                 reqFill,
  input  logic                 reqFlush,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [TS_W-1:0]      cycleNow,
  input  wayEntry_t [WAYS-1:0] row,
  input  logic [CNT_W-1:0]     dirtyCnt,
  output logic [SET_W-1:0]     rdSet,
  output storeCmd_t            cmd,
  output rsp_t                 rspNext
);
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  matchV, validV, dirtyV, resvV;

  assign rdSet  = reqAddr[OFF_W +: SET_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign matchV[w] = (row[w].tag == reqTag);
    assign validV[w] = row[w].valid;
    assign dirtyV[w] = row[w].dirty;
    assign resvV[w]  = row[w].resv;
  end

  // {found, index} of the lowest set bit
  function automatic logic [WAY_W:0] firstOf(input logic [WAYS-1:0] m);
    logic [WAY_W:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (m[w]) r = {1'b1, WAY_W'(w)};
    return r;
  endfunction

  // {found, index} of the oldest candidate; lower index wins ties
  function automatic logic [WAY_W:0] oldestOf(input logic [WAYS-1:0] m,
                                              input wayEntry_t [WAYS-1:0] rw,
                                              input logic useFetch);
    logic            found;
    logic [WAY_W-1:0] idx;
    logic [TS_W-1:0] best, key;
    found = 1'b0; idx = '0; best = '0;
    for (int w = 0; w < WAYS; w++) begin
      key = useFetch ? rw[w].fetchTime : rw[w].lastUsed;
      if (m[w] && (!found || key < best)) begin
        found = 1'b1; idx = WAY_W'(w); best = key;
      end
    end
    return {found, idx};
  endfunction

  logic [WAY_W:0]   hitSel, wtSlot, freeSel, vicWt, vicWb;
  logic [WAY_W-1:0] hitIdx, wtIdx, freeIdx, vicWtIdx, vicWbIdx;
  wayEntry_t        fresh;

  assign hitSel  = firstOf(matchV & (resvV | validV));
  assign wtSlot  = firstOf(~validV | (matchV & validV));
  assign freeSel = firstOf(~validV & ~resvV);
  assign vicWt   = oldestOf(validV, row, fifoMode);
  assign vicWb   = oldestOf(validV & ~resvV, row, fifoMode);
  assign hitIdx   = hitSel[WAY_W-1:0];
  assign wtIdx    = wtSlot[WAY_W-1:0];
  assign freeIdx  = freeSel[WAY_W-1:0];
  assign vicWtIdx = vicWt[WAY_W-1:0];
  assign vicWbIdx = vicWb[WAY_W-1:0];

  always_comb begin
    fresh           = '0;
    fresh.tag       = reqTag;
    fresh.addr      = reqAddr;
    fresh.valid     = 1'b1;
    fresh.lastUsed  = cycleNow;
    fresh.fetchTime = cycleNow;
  end

  always_comb begin
    cmd     = '0;
    rspNext = '0;
    cmd.set = rdSet;
    if (reqFlush) begin
      cmd.flushAll     = 1'b1;
      rspNext.valid    = 1'b1;
      rspNext.code     = RSP_FLUSHED;
      rspNext.flushCnt = dirtyCnt;
    end else if (reqFill) begin
      rspNext.valid = 1'b1;
      rspNext.code  = RSP_FILLED;
      if (wbMode) begin
        if (hitSel[WAY_W] && resvV[hitIdx]) begin
          cmd.lineWr          = 1'b1;
          cmd.way             = hitIdx;
          cmd.entry           = fresh;
          cmd.entry.dirty     = dirtyV[hitIdx];
        end
      end else if (wtSlot[WAY_W]) begin
        if (!validV[wtIdx]) begin
          cmd.lineWr = 1'b1;
          cmd.way    = wtIdx;
          cmd.entry  = fresh;
        end
      end else begin
        cmd.lineWr = 1'b1;
        cmd.way    = vicWtIdx;
        cmd.entry  = fresh;
        if (dirtyV[vicWtIdx]) begin
          rspNext.evict = 1'b1;
          rspNext.addr  = row[vicWtIdx].addr;
        end
      end
    end else if (reqLookup) begin
      rspNext.valid = 1'b1;
      if (hitSel[WAY_W]) begin
        cmd.way   = hitIdx;
        cmd.entry = row[hitIdx];
        if (resvV[hitIdx]) begin
          rspNext.code = RSP_HIT_PEND;
          if (reqWrite) begin
            cmd.lineWr      = 1'b1;
            cmd.entry.dirty = 1'b1;
          end
        end else begin
          rspNext.code       = wbMode ? RSP_HIT : RSP_HIT_WT;
          cmd.lineWr         = 1'b1;
          cmd.entry.lastUsed = cycleNow;
          if (reqWrite) cmd.entry.dirty = 1'b1;
        end
      end else if (!wbMode || reqWrite) begin
        rspNext.code = RSP_MISS;
      end else if (&resvV) begin
        rspNext.code = RSP_RESV_FAIL;
      end else if (freeSel[WAY_W]) begin
        rspNext.code   = RSP_MISS;
        cmd.lineWr     = 1'b1;
        cmd.way        = freeIdx;
        cmd.entry      = row[freeIdx];
        cmd.entry.tag  = reqTag;
        cmd.entry.resv = 1'b1;
      end else begin
        cmd.lineWr      = 1'b1;
        cmd.way         = vicWbIdx;
        cmd.entry       = row[vicWbIdx];
        cmd.entry.tag   = reqTag;
        cmd.entry.valid = 1'b0;
        cmd.entry.dirty = 1'b0;
        cmd.entry.resv  = 1'b1;
        if (dirtyV[vicWbIdx]) begin
          rspNext.code  = RSP_MISS_WB;
          rspNext.evict = 1'b1;
          rspNext.addr  = row[vicWbIdx].addr;
        end else begin
          rspNext.code = RSP_MISS;
        end
      end
    end
  end

  // R5: write-through traffic never creates a reservation
  a_r5_wt_no_reserve: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.lineWr && !wbMode) |-> !cmd.entry.resv);

  // R9: completing a reservation preserves a dirty flag set while pending
  a_r9_fill_keeps_dirty: assert property (@(posedge clk) disable iff (!rstN)
    (reqFill && !reqFlush && wbMode && cmd.lineWr) |-> (cmd.entry.dirty == row[cmd.way].dirty));

  // R8: a failed reservation only occurs with a fully reserved set, and writes nothing
  a_r8_fail_full_set: assert property (@(posedge clk) disable iff (!rstN)
    (rspNext.valid && rspNext.code == RSP_RESV_FAIL) |-> ($countones(resvV) == WAYS && !cmd.lineWr));
endmodule

// File: rtl/reserving_tag_ctrl.sv
module reserving_tag_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbMode,
  input  logic              fifoMode,
  input  logic              reqLookup,
  input  logic              reqFill,
  input  logic              reqFlush,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [2:0]        rspCode,
  output logic              rspEvict,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [CNT_W-1:0]  rspFlushCnt
);
  logic [TS_W-1:0]      cycleNow;
  storeCmd_t            cmd;
  wayEntry_t [WAYS-1:0] row;
  logic [SET_W-1:0]     rdSet;
  logic [CNT_W-1:0]     dirtyCnt;
  rsp_t                 rspNext, rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleNow <= '0;
      rspQ     <= '0;
    end else begin
      cycleNow <= cycleNow + TS_W'(1);
      rspQ     <= rspNext;
    end
  end

  rtc_store u_store (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdSet(rdSet),
    .rowOut(row), .dirtyCnt(dirtyCnt)
  );

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wbMode(wbMode), .fifoMode(fifoMode),
    .reqLookup(reqLookup), .reqFill(reqFill), .reqFlush(reqFlush),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .cycleNow(cycleNow),
    .row(row), .dirtyCnt(dirtyCnt), .rdSet(rdSet), .cmd(cmd), .rspNext(rspNext)
  );

  assign rspValid    = rspQ.valid;
  assign rspCode     = rspQ.code;
  assign rspEvict    = rspQ.evict;
  assign rspAddr     = rspQ.addr;
  assign rspFlushCnt = rspQ.flushCnt;

  // R2: every accepted request answers one cycle later
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    (reqLookup || reqFill || reqFlush) |=> rspValid);

  // R2: no request, no response
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(reqLookup || reqFill || reqFlush) |=> !rspValid);

  // R2: flush outranks the other requests
  a_r2_flush_wins: assert property (@(posedge clk) disable iff (!rstN)
    reqFlush |=> (rspCode == 3'd7));

  // R7: a writeback address only comes with a miss-with-writeback or a fill
  a_r7_evict_code: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspEvict) |-> (rspCode == 3'd4 || rspCode == 3'd6));
endmodule

// File: tb/reserving_tag_ctrl_test.sv
`timescale 1ns/1ps
module reserving_tag_ctrl_test;
  import rtc_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wbMode = 1'b1, fifoMode = 1'b0;
  logic reqLookup = 1'b0, reqFill = 1'b0, reqFlush = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic rspValid, rspEvict;
  logic [2:0] rspCode;
  logic [ADDR_W-1:0] rspAddr;
  logic [CNT_W-1:0] rspFlushCnt;

  always #2.5 clk = ~clk;

  reserving_tag_ctrl uut (
    .clk(clk), .rstN(rstN), .wbMode(wbMode), .fifoMode(fifoMode),
    .reqLookup(reqLookup), .reqFill(reqFill), .reqFlush(reqFlush),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspCode(rspCode), .rspEvict(rspEvict), .rspAddr(rspAddr),
    .rspFlushCnt(rspFlushCnt)
  );

  int nCheck = 0, nFail = 0;

  // reference model state
  int  mTag [SETS][WAYS];
  int  mAddr[SETS][WAYS];
  bit  mV   [SETS][WAYS];
  bit  mD   [SETS][WAYS];
  bit  mR   [SETS][WAYS];
  longint mLU[SETS][WAYS];
  longint mFT[SETS][WAYS];
  longint mCyc;
  bit  eV, eEv;
  int  eCode, eAddr, eCnt;

  function automatic int mk(int t, int s);
    return (t << (OFF_W + SET_W)) | (s << OFF_W) | 1;
  endfunction

  function automatic longint keyOf(int s, int w);
    return fifoMode ? mFT[s][w] : mLU[s][w];
  endfunction

  function automatic int pick(int s, bit needUnres);
    int v = -1;
    for (int w = 0; w < WAYS; w++)
      if (mV[s][w] && !(needUnres && mR[s][w]))
        if (v < 0 || keyOf(s, w) < keyOf(s, v)) v = w;
    return v;
  endfunction

  task automatic clearModel();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mTag[s][w] = 0; mAddr[s][w] = 0; mV[s][w] = 0; mD[s][w] = 0;
        mR[s][w] = 0; mLU[s][w] = 0; mFT[s][w] = 0;
      end
    mCyc = 0;
  endtask

  task automatic putLine(int s, int w, int t, int a, bit d);
    mTag[s][w] = t; mAddr[s][w] = a; mV[s][w] = 1; mD[s][w] = d; mR[s][w] = 0;
    mLU[s][w] = mCyc; mFT[s][w] = mCyc;
  endtask

  task automatic model(bit lk, bit fl, bit fs, bit wr, int a);
    int s, t, hit, v;
    s = (a >> OFF_W) & (SETS - 1);
    t = a >> (OFF_W + SET_W);
    eV = lk | fl | fs; eEv = 0; eAddr = 0; eCnt = 0; eCode = 0;
    if (fs) begin
      eCode = 7;
      for (int i = 0; i < SETS; i++)
        for (int w = 0; w < WAYS; w++) begin
          if (mV[i][w] && mD[i][w]) eCnt++;
          mV[i][w] = 0; mD[i][w] = 0;
        end
    end else if (fl) begin
      eCode = 6;
      if (wbMode) begin
        for (int w = 0; w < WAYS; w++) begin
          if (mTag[s][w] == t && mR[s][w]) begin putLine(s, w, t, a, mD[s][w]); break; end
          if (mTag[s][w] == t && mV[s][w]) break;
        end
      end else begin
        hit = -1; v = 0;
        for (int w = 0; w < WAYS; w++) begin
          if (!mV[s][w]) begin hit = w; break; end
          if (mTag[s][w] == t) begin hit = w; v = 1; break; end
        end
        if (hit < 0) begin
          hit = pick(s, 0);
          if (mD[s][hit]) begin eEv = 1; eAddr = mAddr[s][hit]; end
        end
        if (!v) putLine(s, hit, t, a, 0);
      end
    end else if (lk) begin
      hit = -1;
      for (int w = 0; w < WAYS; w++)
        if (mTag[s][w] == t && (mR[s][w] || mV[s][w])) begin hit = w; break; end
      if (hit >= 0 && mR[s][hit]) begin
        eCode = 2; if (wr) mD[s][hit] = 1;
      end else if (hit >= 0) begin
        eCode = wbMode ? 0 : 1; mLU[s][hit] = mCyc; if (wr) mD[s][hit] = 1;
      end else if (!wbMode || wr) begin
        eCode = 3;
      end else begin
        v = 1;
        for (int w = 0; w < WAYS; w++) if (!mR[s][w]) v = 0;
        if (v) eCode = 5;
        else begin
          hit = -1;
          for (int w = 0; w < WAYS; w++)
            if (!mV[s][w] && !mR[s][w]) begin hit = w; break; end
          if (hit >= 0) begin
            eCode = 3; mTag[s][hit] = t; mR[s][hit] = 1;
          end else begin
            hit = pick(s, 1);
            if (mD[s][hit]) begin eCode = 4; eEv = 1; eAddr = mAddr[s][hit]; end
            else eCode = 3;
            mTag[s][hit] = t; mV[s][hit] = 0; mD[s][hit] = 0; mR[s][hit] = 1;
          end
        end
      end
    end
  endtask

  function automatic string tagOf(int c);
    case (c)
      0, 1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R11";
    endcase
  endfunction

  // called at a falling edge; drives one request and judges its response
  task automatic step(string rq, bit lk, bit fl, bit fs, bit wr, int a);
    string tg;
    bit bad;
    reqLookup = lk; reqFill = fl; reqFlush = fs; reqWrite = wr; reqAddr = ADDR_W'(a);
    model(lk, fl, fs, wr, a);
    @(posedge clk);
    mCyc++;
    @(negedge clk);
    tg = (rq == "") ? (eV ? tagOf(eCode) : "R2") : rq;
    nCheck++;
    bad = (rspValid !== eV);
    if (eV) begin
      if (rspCode !== 3'(eCode) || rspEvict !== eEv) bad = 1;
      if (eEv && rspAddr !== ADDR_W'(eAddr)) bad = 1;
      if (eCode == 7 && rspFlushCnt !== CNT_W'(eCnt)) bad = 1;
    end
    if (bad) begin
      nFail++;
      $display("FAIL %s: got v=%0d code=%0d ev=%0d addr=%0h cnt=%0d, want v=%0d code=%0d ev=%0d addr=%0h cnt=%0d",
               tg, rspValid, rspCode, rspEvict, rspAddr, rspFlushCnt, eV, eCode, eEv, eAddr, eCnt);
    end
  endtask

  task automatic idle();
    step("R2", 0, 0, 0, 0, 0);
  endtask

  task automatic doReset(bit wb, bit ff);
    @(negedge clk);
    rstN = 0; wbMode = wb; fifoMode = ff;
    reqLookup = 0; reqFill = 0; reqFlush = 0; reqWrite = 0;
    repeat (3) @(negedge clk);
    nCheck++;
    if (rspValid !== 1'b0) begin
      nFail++;
      $display("FAIL R12: got rspValid=%0d, want 0", rspValid);
    end
    rstN = 1;
    clearModel();
  endtask

  task automatic randomTraffic(int n);
    for (int i = 0; i < n; i++) begin
      int op, a;
      op = $urandom_range(0, 99);
      a = mk($urandom_range(1, 6), $urandom_range(0, 1));
      step("", op < 55 || op >= 93, op >= 55 && op < 93, op >= 97,
           $urandom_range(0, 9) < 4, a);
    end
  endtask

  task automatic wbPhase(bit ff);
    doReset(1, ff);
    // R12: empty after reset, so a read miss takes way 0 cleanly
    for (int t = 1; t <= 4; t++) step("R6", 1, 0, 0, 0, mk(t, 0));
    step("R8", 1, 0, 0, 0, mk(5, 0));
    step("R4", 1, 0, 0, 1, mk(2, 0));
    // R1: another set is unaffected by set 0 being full
    step("R1", 1, 0, 0, 0, mk(5, 1));
    step("R2", 1, 1, 0, 1, mk(1, 0));   // fill beats a write lookup
    step("R9", 0, 1, 0, 0, mk(2, 0));
    step("R9", 0, 1, 0, 0, mk(3, 0));
    step("R9", 0, 1, 0, 0, mk(4, 0));
    step("R9", 0, 1, 0, 0, mk(2, 0));   // duplicate fill discarded
    step("R2", 1, 0, 0, 0, mk(1, 0));   // clean hit: the losing write left no dirty flag
    step("R3", 1, 0, 0, 1, mk(3, 0));
    idle();
    step("R7", 1, 0, 0, 0, mk(7, 0));
    step("R7", 1, 0, 0, 0, mk(8, 0));
    step("R5", 1, 0, 0, 1, mk(9, 0));
    step("R9", 0, 1, 0, 0, mk(7, 0));
    step("R2", 1, 0, 1, 0, mk(6, 1));   // flush beats lookup
    step("R11", 1, 0, 0, 0, mk(7, 0));
    step("R11", 1, 0, 0, 0, mk(6, 1));  // no reservation left by the losing lookup
    randomTraffic(500);
  endtask

  task automatic wtPhase(bit ff);
    doReset(0, ff);
    for (int t = 1; t <= 4; t++) step("R10", 0, 1, 0, 0, mk(t, 2));
    step("R10", 0, 1, 0, 0, mk(3, 2));  // already present
    step("R3", 1, 0, 0, 1, mk(2, 2));
    step("R3", 1, 0, 0, 0, mk(1, 2));
    step("R5", 1, 0, 0, 0, mk(9, 2));
    step("R10", 0, 1, 0, 0, mk(9, 2));
    step("R10", 0, 1, 0, 0, mk(10, 2));
    step("R10", 0, 1, 0, 0, mk(11, 2));
    step("R11", 0, 1, 1, 0, mk(12, 2));
    step("R11", 1, 0, 0, 0, mk(12, 2));
    randomTraffic(500);
  endtask

  initial begin
    wbPhase(0);
    wbPhase(1);
    wtPhase(0);
    wtPhase(1);
    idle();
    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  end

  initial begin
    #500000;
    nCheck++;
    nFail++;
    $display("FAIL R2: watchdog expired, got hung run, want completion");
    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  end
endmodule